// File: doc/BRIEF.md
# Software Trap Entry and System Register Read Unit

This unit carries out the architectural side effects of a software trap instruction and serves reads of the processor's system registers. When the pipeline presents a trap request with a 5-bit vector, the unit does all of the following on a single clock edge:

- saves the address of the following instruction;
- saves the current status word;
- records an exception code derived from the vector;
- raises the exception-pending and interrupt-disable flags in the status word;
- issues a one-cycle redirect carrying the handler address.

A separate read port returns the system register selected by a 5-bit identifier, combinationally, for writeback into a general register. IDs that name no register read as zero. All state resets to zero.

Top module: `sys_trap_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `redirectValid` is 0 and every identifier 0..31 reads 0 on `sregData`.
- R2: A trap accepted on a clock edge stores `pcNext` into the saved-PC register, which reads at ID 0 from the next cycle.
- R3: A trap stores the status word as it stood before that trap into the saved-status register, which reads at ID 1.
- R4: A trap writes 0x40 plus the vector into bits 15:0 of the cause register (ID 4), and keeps bits 31:16 of that register unchanged.
- R5: A trap sets status bit 6 (exception pending) and status bit 5 (interrupt disable), and keeps every other status bit. The status word reads at ID 5.
- R6: On the cycle after an accepted trap, `redirectValid` is 1 for exactly one cycle, unless another trap follows. `redirectPc` is then 0x40 for vectors 0..15 and 0x50 for vectors 16..31.
- R7: IDs 2, 3 and 6..31 always read as zero.
- R8: `sregData` follows `sregSel` combinationally, in the same cycle and without a clock edge.
- R9: Traps on consecutive cycles each commit fully. The second trap saves the status word that the first trap left, with both flags set.
- R10: On cycles with no trap request, none of the four system registers changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | Trap instruction commits this cycle |
| trapVector | input | 5 | Trap vector number |
| pcNext | input | 32 | Address of the instruction after the trap |
| sregSel | input | 5 | System register identifier to read |
| sregData | output | 32 | Selected system register value |
| redirectValid | output | 1 | One-cycle fetch redirect strobe |
| redirectPc | output | 32 | Handler address for the redirect |

## Verification
Saved state has no port of its own, so a wrong value in a save register, the cause code or the status flags stays hidden until that ID is read. The bench therefore reads all four registers through `sregSel` on the cycle right after each trap, which is the first cycle the new value can be seen.

A wrong handler selection or a stuck strobe shows on `redirectValid` and `redirectPc` on that same cycle, or on the cycle after it. A flag that is lost before a second trap shows only in the saved-status value of that later trap, so the bench also runs back-to-back traps.

// File: rtl/sys_trap_pkg.sv
package sys_trap_pkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic saveCtx;     // capture return address and status word
    logic writeCause;  // load exception code into cause low field
    logic raiseFlags;  // set pending and interrupt-disable flags
    logic loadTarget;  // load handler address into redirect register
  } trapStrobes_t;

  localparam int EXC_PEND_BIT = 6;
  localparam int INT_DIS_BIT  = 5;
  localparam int CODE_W       = 16;

  localparam logic [4:0] SR_SAVED_PC     = 5'd0;
  localparam logic [4:0] SR_SAVED_STATUS = 5'd1;
  localparam logic [4:0] SR_CAUSE        = 5'd4;
  localparam logic [4:0] SR_STATUS       = 5'd5;

endpackage

// File: rtl/sys_trap_ctrl.sv
module sys_trap_ctrl
  import sys_trap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trapReq,
  output trapStrobes_t strobes,
  output logic         redirectValid
);

  logic redirectQ;

  // Every side effect of the trap commits on the same edge.
  always_comb begin
    strobes            = '0;
    strobes.saveCtx    = trapReq;
    strobes.writeCause = trapReq;
    strobes.raiseFlags = trapReq;
    strobes.loadTarget = trapReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) redirectQ <= 1'b0;
    else       redirectQ <= trapReq;
  end

  assign redirectValid = redirectQ;

endmodule

// File: rtl/sys_trap_dp.sv
module sys_trap_dp
  import sys_trap_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          VEC_W        = 5,
  parameter int          ID_W         = 5,
  parameter logic [15:0] CODE_BASE    = 16'h0040,
  parameter logic [31:0] LOW_HANDLER  = 32'h0000_0040,
  parameter logic [31:0] HIGH_HANDLER = 32'h0000_0050
) (
  input  logic             clk,
  input  logic             rstN,
  input  trapStrobes_t     strobes,
  input  logic [VEC_W-1:0] trapVector,
  input  logic [XLEN-1:0]  pcNext,
  input  logic [ID_W-1:0]  sregSel,
  output logic [XLEN-1:0]  sregData,
  output logic [XLEN-1:0]  redirectPc,
  output logic [XLEN-1:0]  savedPcQ,
  output logic [XLEN-1:0]  savedStatusQ,
  output logic [XLEN-1:0]  causeQ,
  output logic [XLEN-1:0]  statusQ
);

  localparam int UPPER_W = XLEN - CODE_W;

  logic [CODE_W-1:0] excCode;
  logic [XLEN-1:0]   handlerAddr;
  logic [XLEN-1:0]   flagMask;
  logic [XLEN-1:0]   targetQ;

  assign excCode = CODE_BASE + CODE_W'(trapVector);

  // The vector's top bit picks one of two handler entry points.
  assign handlerAddr = trapVector[VEC_W-1] ? XLEN'(HIGH_HANDLER)
                                           : XLEN'(LOW_HANDLER);

  always_comb begin
    flagMask              = '0;
    flagMask[EXC_PEND_BIT] = 1'b1;
    flagMask[INT_DIS_BIT]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPcQ     <= '0;
      savedStatusQ <= '0;
    end else if (strobes.saveCtx) begin
      savedPcQ     <= pcNext;
      savedStatusQ <= statusQ;
    end
  end

  generate
    if (UPPER_W > 0) begin : g_wideCause
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   causeQ <= '0;
        else if (strobes.writeCause) causeQ <= {causeQ[XLEN-1:CODE_W], excCode};
      end
    end else begin : g_narrowCause
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   causeQ <= '0;
        else if (strobes.writeCause) causeQ <= excCode[XLEN-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   statusQ <= '0;
    else if (strobes.raiseFlags) statusQ <= statusQ | flagMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   targetQ <= '0;
    else if (strobes.loadTarget) targetQ <= handlerAddr;
  end

  assign redirectPc = targetQ;

  // IDs without a register read back as zero.
  always_comb begin
    case (sregSel)
      ID_W'(SR_SAVED_PC):     sregData = savedPcQ;
      ID_W'(SR_SAVED_STATUS): sregData = savedStatusQ;
      ID_W'(SR_CAUSE):        sregData = causeQ;
      ID_W'(SR_STATUS):       sregData = statusQ;
      default:                sregData = '0;
    endcase
  end

endmodule

// File: rtl/sys_trap_unit.sv
module sys_trap_unit
  import sys_trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 5,
  parameter int ID_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapReq,
  input  logic [VEC_W-1:0] trapVector,
  input  logic [XLEN-1:0]  pcNext,
  input  logic [ID_W-1:0]  sregSel,
  output logic [XLEN-1:0]  sregData,
  output logic             redirectValid,
  output logic [XLEN-1:0]  redirectPc
);

  trapStrobes_t    strobes;
  logic [XLEN-1:0] savedPcQ;
  logic [XLEN-1:0] savedStatusQ;
  logic [XLEN-1:0] causeQ;
  logic [XLEN-1:0] statusQ;

  sys_trap_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .trapReq       (trapReq),
    .strobes       (strobes),
    .redirectValid (redirectValid)
  );

  sys_trap_dp #(
    .XLEN  (XLEN),
    .VEC_W (VEC_W),
    .ID_W  (ID_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .trapVector   (trapVector),
    .pcNext       (pcNext),
    .sregSel      (sregSel),
    .sregData     (sregData),
    .redirectPc   (redirectPc),
    .savedPcQ     (savedPcQ),
    .savedStatusQ (savedStatusQ),
    .causeQ       (causeQ),
    .statusQ      (statusQ)
  );

endmodule

// File: rtl/sys_trap_checker.sv
module sys_trap_checker #(
  parameter int XLEN  = 32,
  parameter int VEC_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             trapReq,
  input logic [VEC_W-1:0] trapVector,
  input logic [XLEN-1:0]  pcNext,
  input logic             redirectValid,
  input logic [XLEN-1:0]  redirectPc,
  input logic [XLEN-1:0]  savedPc,
  input logic [XLEN-1:0]  savedStatus,
  input logic [XLEN-1:0]  causeVal,
  input logic [XLEN-1:0]  statusVal
);

  a_r2_save_pc: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> savedPc == $past(pcNext));

  a_r3_save_status: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> savedStatus == $past(statusVal));

  a_r4_cause_code: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> (causeVal[15:0] == 16'h0040 + 16'($past(trapVector)))
                && (causeVal[XLEN-1:16] == $past(causeVal[XLEN-1:16])));

  a_r5_flags_set: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> statusVal[6] && statusVal[5]);

  a_r6_strobe_on: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> redirectValid);

  a_r6_strobe_off: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> !redirectValid);

  a_r6_target: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> redirectPc == ($past(trapVector[VEC_W-1]) ? XLEN'(32'h50)
                                                          : XLEN'(32'h40)));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> $stable(savedPc) && $stable(savedStatus)
                 && $stable(causeVal) && $stable(statusVal));

endmodule

bind sys_trap_unit sys_trap_checker #(.XLEN(XLEN), .VEC_W(VEC_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .trapReq       (trapReq),
  .trapVector    (trapVector),
  .pcNext        (pcNext),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc),
  .savedPc       (savedPcQ),
  .savedStatus   (savedStatusQ),
  .causeVal      (causeQ),
  .statusVal     (statusQ)
);

// File: tb/tb_sys_trap_unit.sv
`timescale 1ns/1ps
module tb_sys_trap_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [4:0]  trapVector = '0;
  logic [31:0] pcNext = '0;
  logic [4:0]  sregSel = '0;
  logic [31:0] sregData;
  logic        redirectValid;
  logic [31:0] redirectPc;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] expSavedPc = '0;
  logic [31:0] expSavedStatus = '0;
  logic [31:0] expCause = '0;
  logic [31:0] expStatus = '0;

  always #5 clk = ~clk;

  sys_trap_unit dut (
    .clk           (clk),
    .rstN          (rstN),
    .trapReq       (trapReq),
    .trapVector    (trapVector),
    .pcNext        (pcNext),
    .sregSel       (sregSel),
    .sregData      (sregData),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [4:0] id, output logic [31:0] val);
    sregSel = id;
    #1;
    val = sregData;
  endtask

  task automatic checkRegs(input string ctx);
    logic [31:0] v;
    readReg(5'd0, v); check({"R2 saved pc ", ctx}, v, expSavedPc);
    readReg(5'd1, v); check({"R3 saved status ", ctx}, v, expSavedStatus);
    readReg(5'd4, v); check({"R4 cause ", ctx}, v, expCause);
    readReg(5'd5, v); check({"R5 status ", ctx}, v, expStatus);
  endtask

  function automatic logic [31:0] handlerFor(input logic [4:0] v);
    return v[4] ? 32'h50 : 32'h40;
  endfunction

  task automatic modelTrap(input logic [4:0] v, input logic [31:0] pc);
    expSavedStatus = expStatus;
    expSavedPc     = pc;
    expCause       = {expCause[31:16], 16'h0040 + {11'd0, v}};
    expStatus      = expStatus | 32'h0000_0060;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 redirect in reset", {31'd0, redirectValid}, 32'd0);
    for (int i = 0; i < 32; i++) begin
      readReg(5'(i), v);
      check($sformatf("R1 id %0d in reset", i), v, 32'd0);
    end
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 redirect after reset", {31'd0, redirectValid}, 32'd0);
    checkRegs("after reset");
  endtask

  task automatic testSingleTrap(input logic [4:0] v, input logic [31:0] pc);
    @(negedge clk);
    trapReq = 1'b1; trapVector = v; pcNext = pc;
    @(negedge clk);
    trapReq = 1'b0; trapVector = '0; pcNext = 32'hDEAD_BEEF;
    modelTrap(v, pc);
    check($sformatf("R6 strobe vec %0d", v), {31'd0, redirectValid}, 32'd1);
    check($sformatf("R6 target vec %0d", v), redirectPc, handlerFor(v));
    checkRegs($sformatf("vec %0d", v));
    @(negedge clk);
    check($sformatf("R6 strobe drop vec %0d", v), {31'd0, redirectValid}, 32'd0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    trapReq = 1'b1; trapVector = 5'd7; pcNext = 32'h0000_3000;
    @(negedge clk);
    modelTrap(5'd7, 32'h0000_3000);
    check("R9 first strobe", {31'd0, redirectValid}, 32'd1);
    check("R9 first target", redirectPc, 32'h40);
    checkRegs("R9 first");
    trapVector = 5'd20; pcNext = 32'h0000_4008;
    @(negedge clk);
    trapReq = 1'b0;
    modelTrap(5'd20, 32'h0000_4008);
    check("R9 second strobe", {31'd0, redirectValid}, 32'd1);
    check("R9 second target", redirectPc, 32'h50);
    checkRegs("R9 second");
    @(negedge clk);
    check("R9 strobe drop", {31'd0, redirectValid}, 32'd0);
  endtask

  task automatic testUnimplemented();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      if (i != 0 && i != 1 && i != 4 && i != 5) begin
        readReg(5'(i), v);
        check($sformatf("R7 id %0d", i), v, 32'd0);
      end
    end
  endtask

  task automatic testCombRead();
    sregSel = 5'd5;
    #1;
    check("R8 status read", sregData, expStatus);
    sregSel = 5'd0;
    #1;
    check("R8 switch to saved pc", sregData, expSavedPc);
  endtask

  task automatic testIdle();
    @(negedge clk);
    trapVector = 5'd31; pcNext = 32'h1234_5678;
    repeat (5) @(negedge clk);
    check("R10 no strobe while idle", {31'd0, redirectValid}, 32'd0);
    checkRegs("R10 idle");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #2;
    testReset();
    testSingleTrap(5'd3,  32'h0000_1004);
    testSingleTrap(5'd16, 32'h0000_2000);
    testSingleTrap(5'd31, 32'hFFFF_FFFC);
    testSingleTrap(5'd15, 32'h0000_0100);
    testSingleTrap(5'd0,  32'h8000_0000);
    testBackToBack();
    testUnimplemented();
    testCombRead();
    testIdle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule